// File: doc/BRIEF.md
# Gated Four-Lane Differential Clock Fan-Out

This block takes one free-running clock and drives four copies of it, each as a true/complement output pair. Every lane has its own active-high enable pin. Every lane also has a control bit held in a small bank of four byte-wide registers, and the lane runs only while both are high. The register bank sits on its own configuration clock. It is written and read through a plain synchronous port: a write strobe, a byte address, write data and a combinational read-back.

The per-lane enable is the AND of the pin and the control bit. It is carried into the output clock domain by a chain of falling-edge flops. A stopped lane finishes the phase it is in, and after that both of its legs rest low. A lane that is switched back on picks up at a phase boundary, so neither leg ever shows a shortened pulse. After reset the control bits come up set. With the pins held high, all four lanes therefore run without any configuration writes.

Top module: `clkgate_bank`

## Requirements
- R1: The register bank holds four bytes at addresses 0 to 3. A byte is written at a rising edge of `cfg_clk` while `cfg_we` is high. `cfg_rdata` shows all eight bits of the byte at `cfg_addr` without waiting for a clock edge.
- R2: While `cfg_rst_n` is low, the register bytes take the values 0x00 (address 0), 0x05 (address 1), 0xC0 (address 2) and 0x00 (address 3). With every enable pin held high, all four lanes then toggle.
- R3: The lane control bits are: lane 0 at address 1 bit 2, lane 1 at address 1 bit 0, lane 2 at address 2 bit 7, lane 3 at address 2 bit 6. A lane's combined enable is its pin AND its control bit.
- R4: The register bits not listed in R3 are stored and read back, but they do not change any output leg.
- R5: The combined enable sampled at falling edge k of `clk_in` decides the true leg during the high phase that follows falling edge k+1. When that enable is set, the true leg is high for that whole high phase; when it is clear, the true leg is low.
- R6: The combined enable sampled at falling edge k decides the complement leg during the low phase that follows falling edge k+2. When that enable is set, the complement leg is high for that whole low phase; when it is clear, the complement leg is low.
- R7: The true leg is high only while `clk_in` is high, and the complement leg only while `clk_in` is low. The two legs are never high together, and a stopped lane keeps both legs low.
- R8: While `clk_rst_n` is low, every leg is low. After release, the enable chain starts cleared and then follows R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock copied onto all lanes |
| clk_rst_n | input | 1 | Active-low asynchronous reset of the output clock domain |
| oe_pin | input | 4 | Per-lane hardware enable, active high |
| cfg_clk | input | 1 | Register port clock |
| cfg_rst_n | input | 1 | Active-low asynchronous reset of the register bank |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 2 | Byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed byte |
| out_p | output | 4 | True leg per lane |
| out_n | output | 4 | Complement leg per lane |

## Verification
The lanes are exercised in several ways:
- Lowering one pin at a time shows which lane each pin controls.
- Clearing control bits at the listed positions shows that the register map and the AND are right. Setting every other bit shows that those bits are ignored.
- A pseudo-random pin sequence that changes every cycle checks the two-edge latency. It also exposes any difference between the true-leg and complement-leg timing, because a behavioural model of both legs is compared in every half period.
- A reset in the middle of the run shows that both legs park low and that the lanes restart from a cleared chain.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/100ps
package clkgate_pkg;
  localparam int unsigned NUM_OUT   = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = 4;
  localparam int unsigned ADDR_W    = $clog2(NUM_BYTES);
  localparam int unsigned BIT_W     = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [ADDR_W-1:0] idx;
    logic [BIT_W-1:0]  pos;
  } ctl_loc_t;

  // Location of each lane's control bit (fixed map, decoded by software)
  function automatic ctl_loc_t ctl_loc(input int unsigned lane);
    ctl_loc_t l;
    case (lane)
      0:       begin l.idx = ADDR_W'(1); l.pos = BIT_W'(2); end
      1:       begin l.idx = ADDR_W'(1); l.pos = BIT_W'(0); end
      2:       begin l.idx = ADDR_W'(2); l.pos = BIT_W'(7); end
      3:       begin l.idx = ADDR_W'(2); l.pos = BIT_W'(6); end
      default: l = '0;
    endcase
    return l;
  endfunction

  // Reset image of one byte: every mapped control bit set, all else clear
  function automatic byte_t reset_byte(input int unsigned b);
    byte_t v;
    v = '0;
    for (int unsigned n = 0; n < NUM_OUT; n++) begin
      if (32'(ctl_loc(n).idx) == b) v[ctl_loc(n).pos] = 1'b1;
    end
    return v;
  endfunction

  // Combined lane enable: pin AND register bit
  function automatic logic [NUM_OUT-1:0] combine_en(input logic [NUM_OUT-1:0] pins,
                                                    input logic [NUM_OUT-1:0] ctl);
    return pins & ctl;
  endfunction
endpackage

// File: rtl/clkgate_regs.sv
`timescale 1ns/100ps
module clkgate_regs
  import clkgate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  byte_t              wdata,
  output byte_t              rdata,
  output logic [NUM_OUT-1:0] ctl_en
);
  byte_t bank [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam byte_t RST_VAL = reset_byte(b);
    byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= RST_VAL;
      else if (we && addr == ADDR_W'(b))   q <= wdata;
    end
    assign bank[b] = q;
  end

  assign rdata = bank[addr];

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_ctl
    localparam ctl_loc_t LOC = ctl_loc(n);
    assign ctl_en[n] = bank[LOC.idx][LOC.pos];
  end
endmodule

// File: rtl/clkgate_sync.sv
`timescale 1ns/100ps
module clkgate_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  // Falling-edge chain: the result changes only when clk goes low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgate_leg.sv
`timescale 1ns/100ps
module clkgate_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_lo,
  output logic en_hi,
  output logic out_p,
  output logic out_n
);
  // Re-time for the complement leg so it only switches while ~clk is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_hi <= 1'b0;
    else        en_hi <= en_lo;
  end

  assign out_p = clk & en_lo;
  assign out_n = ~clk & en_hi;
endmodule

// File: rtl/clkgate_bank.sv
`timescale 1ns/100ps
module clkgate_bank
  import clkgate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_in,
  input  logic               clk_rst_n,
  input  logic [NUM_OUT-1:0] oe_pin,
  input  logic               cfg_clk,
  input  logic               cfg_rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0]  cfg_wdata,
  output logic [BYTE_W-1:0]  cfg_rdata,
  output logic [NUM_OUT-1:0] out_p,
  output logic [NUM_OUT-1:0] out_n
);
  logic [NUM_OUT-1:0] ctl_en;
  logic [NUM_OUT-1:0] en_req;
  logic [NUM_OUT-1:0] en_lo;
  logic [NUM_OUT-1:0] en_hi;

  clkgate_regs i_regs (
    .clk    (cfg_clk),
    .rst_n  (cfg_rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .ctl_en (ctl_en)
  );

  assign en_req = combine_en(oe_pin, ctl_en);

  clkgate_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk_in),
    .rst_n (clk_rst_n),
    .d     (en_req),
    .q     (en_lo)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    clkgate_leg i_leg (
      .clk   (clk_in),
      .rst_n (clk_rst_n),
      .en_lo (en_lo[n]),
      .en_hi (en_hi[n]),
      .out_p (out_p[n]),
      .out_n (out_n[n])
    );
  end
endmodule

// File: rtl/clkgate_bank_chk.sv
`timescale 1ns/100ps
module clkgate_bank_chk
  import clkgate_pkg::*;
(
  input logic               clk_in,
  input logic               clk_rst_n,
  input logic               cfg_clk,
  input logic               cfg_rst_n,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [BYTE_W-1:0]  cfg_wdata,
  input logic [BYTE_W-1:0]  cfg_rdata,
  input logic [NUM_OUT-1:0] en_req,
  input logic [NUM_OUT-1:0] en_lo,
  input logic [NUM_OUT-1:0] out_p,
  input logic [NUM_OUT-1:0] out_n
);
  logic [2:0]         neg_cnt;
  logic [NUM_OUT-1:0] req_d1, req_d2;
  logic               live;
  logic               wr_seen;
  logic [ADDR_W-1:0]  wr_addr;
  logic [BYTE_W-1:0]  wr_data;

  always_ff @(negedge clk_in or negedge clk_rst_n) begin
    if (!clk_rst_n) begin
      neg_cnt <= '0;
      req_d1  <= '0;
      req_d2  <= '0;
    end else begin
      if (neg_cnt != 3'd7) neg_cnt <= neg_cnt + 3'd1;
      req_d1 <= en_req;
      req_d2 <= req_d1;
    end
  end

  always_ff @(posedge clk_in or negedge clk_rst_n) begin
    if (!clk_rst_n) live <= 1'b0;
    else            live <= 1'b1;
  end

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      wr_seen <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_seen <= cfg_we;
      wr_addr <= cfg_addr;
      wr_data <= cfg_wdata;
    end
  end

  // R1: a written byte is visible on the read port in the next half period
  p_cfg_readback_r1: assert property (@(negedge cfg_clk) disable iff (!cfg_rst_n)
    (wr_seen && cfg_addr == wr_addr) |-> cfg_rdata == wr_data);

  // R5: the true-leg enable equals the combined enable from two falling edges back
  p_sync_latency_r5: assert property (@(posedge clk_in) disable iff (!clk_rst_n)
    (neg_cnt >= 3'd3) |-> en_lo == req_d2);

  // R7: leg/phase relation and mutual exclusion
  always_comb begin
    if (live) begin
      p_true_in_high_r7: assert ((out_p & {NUM_OUT{~clk_in}}) == '0);
      p_comp_in_low_r7:  assert ((out_n & {NUM_OUT{clk_in}}) == '0);
      p_legs_excl_r7:    assert ((out_p & out_n) == '0);
    end
  end
endmodule

bind clkgate_bank clkgate_bank_chk i_chk (
  .clk_in    (clk_in),
  .clk_rst_n (clk_rst_n),
  .cfg_clk   (cfg_clk),
  .cfg_rst_n (cfg_rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .en_req    (en_req),
  .en_lo     (en_lo),
  .out_p     (out_p),
  .out_n     (out_n)
);

// File: tb/test_clkgate_bank.sv
`timescale 1ns/100ps
module test_clkgate_bank;
  logic       clk_in = 1'b0;
  logic       cfg_clk = 1'b0;
  logic       clk_rst_n = 1'b0;
  logic       cfg_rst_n = 1'b0;
  logic [3:0] oe_pin = 4'hF;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [3:0] out_p, out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  // Bench view of the register bytes and of the lane bit map
  logic [7:0] bm [4] = '{8'h00, 8'h05, 8'hC0, 8'h00};
  int lane_byte [4] = '{1, 1, 2, 2};
  int lane_bit  [4] = '{2, 0, 7, 6};

  logic [3:0] pipe_q [$];
  logic [3:0] en_lo_m = 4'h0;
  logic [3:0] en_hi_m = 4'h0;

  clkgate_bank i_clkgate_bank (
    .clk_in(clk_in), .clk_rst_n(clk_rst_n), .oe_pin(oe_pin),
    .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_p(out_p), .out_n(out_n)
  );

  always #2.5 clk_in = ~clk_in;              // 200 MHz
  initial begin #1; forever #5 cfg_clk = ~cfg_clk; end

  function automatic logic [3:0] req_now();
    logic [3:0] r;
    for (int o = 0; o < 4; o++) r[o] = oe_pin[o] & bm[lane_byte[o]][lane_bit[o]];
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: two falling-edge stages, then a rising-edge stage
  always @(negedge clk_in or negedge clk_rst_n) begin
    if (!clk_rst_n) begin
      pipe_q = {};
      pipe_q.push_back(4'h0);
      en_lo_m = 4'h0;
    end else begin
      pipe_q.push_back(req_now());
      en_lo_m = pipe_q.pop_front();
    end
  end

  always @(posedge clk_in or negedge clk_rst_n) begin
    if (!clk_rst_n) en_hi_m = 4'h0;
    else            en_hi_m = en_lo_m;
  end

  // Per half-period comparison against the model
  always @(posedge clk_in) begin
    #1.25;
    if (cmp_on && clk_rst_n) begin
      chk("R5 true leg high phase", {4'h0, out_p}, {4'h0, en_lo_m});
      chk("R7 complement in high phase", {4'h0, out_n}, 8'h00);
    end
  end

  always @(negedge clk_in) begin
    #1.25;
    if (cmp_on && clk_rst_n) begin
      chk("R6 complement leg low phase", {4'h0, out_n}, {4'h0, en_hi_m});
      chk("R7 true in low phase", {4'h0, out_p}, 8'h00);
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge cfg_clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge cfg_clk); #0.5;
    bm[a] = d;
    #1.5 cfg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk_in);
  endtask

  task automatic at_high();
    @(posedge clk_in); #1.25;
  endtask

  task automatic at_low();
    @(negedge clk_in); #1.25;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // R8: legs low throughout reset, in both phases
    #8.7;  chk("R8 reset high phase p", {4'h0, out_p}, 8'h00);
           chk("R8 reset high phase n", {4'h0, out_n}, 8'h00);
    #2.5;  chk("R8 reset low phase p",  {4'h0, out_p}, 8'h00);
           chk("R8 reset low phase n",  {4'h0, out_n}, 8'h00);
    #11.8; clk_rst_n = 1'b1; cfg_rst_n = 1'b1;  // t = 23
    cmp_on = 1'b1;
    // R2: reset image of the bank
    rd("R2 byte0", 2'd0, 8'h00);
    rd("R2 byte1", 2'd1, 8'h05);
    rd("R2 byte2", 2'd2, 8'hC0);
    rd("R2 byte3", 2'd3, 8'h00);
    run(6);
    at_high(); chk("R2 all lanes on", {4'h0, out_p}, 8'h0F);
    at_low();  chk("R2 all complements on", {4'h0, out_n}, 8'h0F);

    // R3: one pin low at a time
    for (int o = 0; o < 4; o++) begin
      @(posedge clk_in); #0.7 oe_pin = 4'hF & ~(4'h1 << o);
      run(4);
      at_high(); chk("R3 pin off true leg", {4'h0, out_p}, {4'h0, 4'hF & ~(4'h1 << o)});
      at_low();  chk("R7 stopped lane parks", {4'h0, out_n}, {4'h0, 4'hF & ~(4'h1 << o)});
      @(posedge clk_in); #0.7 oe_pin = 4'hF;
      run(4);
    end

    // R3: control bits at their positions
    wr(2'd1, 8'h01); rd("R1 byte1 readback", 2'd1, 8'h01);
    wr(2'd2, 8'h80); rd("R1 byte2 readback", 2'd2, 8'h80);
    run(4);
    at_high(); chk("R3 ctl bits lane0/lane3 off", {4'h0, out_p}, 8'h06);
    wr(2'd1, 8'hFA);
    wr(2'd2, 8'h40);
    run(4);
    at_high(); chk("R3 only lane3 on", {4'h0, out_p}, 8'h08);
    wr(2'd1, 8'h05); wr(2'd2, 8'hC0);

    // R4: unmapped bits stored but inert
    wr(2'd0, 8'hFF); rd("R1 byte0 readback", 2'd0, 8'hFF);
    wr(2'd3, 8'h5A); rd("R1 byte3 readback", 2'd3, 8'h5A);
    wr(2'd1, 8'hFD); rd("R1 byte1 spare bits", 2'd1, 8'hFD);
    wr(2'd2, 8'hFF);
    run(4);
    at_high(); chk("R4 spare bits no effect p", {4'h0, out_p}, 8'h0F);
    wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd1, 8'h07); wr(2'd2, 8'hC3);
    run(4);
    at_low();  chk("R4 spare bits no effect n", {4'h0, out_n}, 8'h0F);
    rd("R4 byte2 keeps spare bits", 2'd2, 8'hC3);

    // R5/R6: pseudo-random pins, changing every cycle
    for (int i = 0; i < 300; i++) begin
      @(posedge clk_in); #0.7;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      oe_pin = (i % 7 == 0) ? 4'hF : lfsr[3:0];
    end
    @(posedge clk_in); #0.7 oe_pin = 4'hF;
    run(5);

    // R8: reset in mid-run
    @(posedge clk_in); #0.3 clk_rst_n = 1'b0;
    #1.0; chk("R8 mid reset p", {4'h0, out_p}, 8'h00);
    #2.5; chk("R8 mid reset n", {4'h0, out_n}, 8'h00);
    run(3);
    #0.3 clk_rst_n = 1'b1;
    at_high(); chk("R8 restart from cleared chain", {4'h0, out_p}, 8'h00);
    run(5);
    at_high(); chk("R8 lanes resume", {4'h0, out_p}, 8'h0F);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule